// File: doc/BRIEF.md
# Partitioned 8x16 Fixed-Point Multiplier

This block is a SIMD multiply unit for pixel arithmetic. Each lane multiplies an unsigned 8-bit pixel component by a signed 16-bit coefficient, producing a 24-bit two's-complement product. The lane keeps product bits [23:8] as its 16-bit result and adds one when product bit 7 is set. The add wraps within 16 bits. A 9-bit operation code selects one of seven variants. The variants differ in where the pixel bytes come from, where the coefficients come from, and where each lane result is placed in the 64-bit output.

The unit takes two 64-bit source operands, `srcA` and `srcB`, along with the operation code and a valid strobe. It returns a 64-bit result with its own valid strobe. The parameter `OUT_STAGE` chooses between two timings:
- `OUT_STAGE=1` (default): the result is registered and appears one clock after the request. It holds its value in cycles without a request.
- `OUT_STAGE=0`: the result is combinational.

Register access and instruction decode live outside the block. Operation codes that are not recognised produce a zero result.

Top module: `pixel_scale_mul`

## Requirements
- R1: With code 0x031, byte i of `srcA` (bits 8i+7:8i, i=0..3) multiplies 16-bit lane i of `srcB` (bits 16i+15:16i). The rounded lane result is written to `result` bits 16i+15:16i.
- R2: Each lane result equals product bits [23:8] plus product bit 7, taken modulo 2^16. The increment wraps and does not saturate. Example: pixel 0x01 times coefficient 0xFFFF gives 0x0000.
- R3: Code 0x033 multiplies all four bytes of `srcA[31:0]` by the single coefficient `srcB[31:16]`. Code 0x035 uses `srcB[15:0]` instead. Lane i result goes to bits 16i+15:16i.
- R4: Codes 0x036 and 0x037 multiply 16-bit lane i of `srcB` by one byte of 16-bit lane i of `srcA`. Code 0x036 uses the high byte (bits 16i+15:16i+8) and code 0x037 uses the low byte (bits 16i+7:16i). Lane i result goes to bits 16i+15:16i.
- R5: Codes 0x038 and 0x039 use two lanes (i=0,1). They select bytes and coefficients as 0x036 and 0x037 do. Lane i result goes to `result` bits 32i+22:32i+7, and every other result bit is zero.
- R6: Bits [63:32] of `srcA` have no effect for codes 0x031, 0x033, 0x035, 0x038 and 0x039. Bits [63:32] of `srcB` have no effect for codes 0x033, 0x035, 0x038 and 0x039.
- R7: Any other operation code yields an all-zero result that is still flagged valid.
- R8: With `OUT_STAGE=1`, `outValid` equals `inValid` delayed by one clock, and `result` changes only in a cycle where `outValid` is high.
- R9: While `rst` is high at a clock edge, the next cycle shows `outValid` low and `result` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe for the current operands |
| opCode | input | 9 | Variant select code |
| srcA | input | 64 | Pixel-byte operand |
| srcB | input | 64 | Coefficient operand |
| outValid | output | 1 | Result strobe |
| result | output | 64 | Packed lane results |

## Verification
A wrong lane-selection or variant decode shows up as a wrong `result` in the very cycle `outValid` rises for that request. The bench compares every cycle, so the fault surfaces one clock after the offending request. A stuck or mis-timed valid register, or an output register that loads outside a request, appears as a mismatch on `outValid` or as a `result` change during an idle cycle, again within one clock. Rounding faults show up only for products whose bit 7 is set, and wrap faults only when bits [23:8] are all ones, so directed operands aim at exactly those products.

// File: rtl/pxmul_pkg.sv
package pxmul_pkg;
  localparam int OPC_W    = 9;
  localparam int DATA_W   = 64;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 16;
  localparam int LANE_CNT = DATA_W / COEF_W;
  localparam int DBL_CNT  = LANE_CNT / 2;
  localparam int DBL_OFS  = 7;
  localparam int PROD_W   = PIX_W + 1 + COEF_W;

  localparam logic [OPC_W-1:0] OPC_LANE     = 9'h031;
  localparam logic [OPC_W-1:0] OPC_ALPHA_HI = 9'h033;
  localparam logic [OPC_W-1:0] OPC_ALPHA_LO = 9'h035;
  localparam logic [OPC_W-1:0] OPC_BYTE_HI  = 9'h036;
  localparam logic [OPC_W-1:0] OPC_BYTE_LO  = 9'h037;
  localparam logic [OPC_W-1:0] OPC_DBL_HI   = 9'h038;
  localparam logic [OPC_W-1:0] OPC_DBL_LO   = 9'h039;

  typedef enum logic [2:0] {
    MODE_NONE,
    MODE_LANE,
    MODE_ALPHA_HI,
    MODE_ALPHA_LO,
    MODE_BYTE_HI,
    MODE_BYTE_LO,
    MODE_DBL_HI,
    MODE_DBL_LO
  } mulMode_t;

  typedef struct packed {
    logic capture;
    logic validNext;
  } ctrlStrobe_t;

  // Middle 16 bits of an unsigned-by-signed product, rounded on bit 7, wrapping.
  function automatic logic [COEF_W-1:0] scaleMid(input logic [PIX_W-1:0] pix,
                                                 input logic [COEF_W-1:0] coef);
    logic signed [PROD_W-1:0] prod;
    prod = $signed({1'b0, pix}) * $signed(coef);
    return prod[PIX_W+COEF_W-1:PIX_W] + {{(COEF_W-1){1'b0}}, prod[PIX_W-1]};
  endfunction
endpackage

// File: rtl/pxmul_ctrl.sv
module pxmul_ctrl
  import pxmul_pkg::*;
#(
  parameter int OUT_STAGE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opCode,
  output mulMode_t         mode,
  output ctrlStrobe_t      strobe,
  output logic             outValid
);
  always_comb begin
    unique case (opCode)
      OPC_LANE:     mode = MODE_LANE;
      OPC_ALPHA_HI: mode = MODE_ALPHA_HI;
      OPC_ALPHA_LO: mode = MODE_ALPHA_LO;
      OPC_BYTE_HI:  mode = MODE_BYTE_HI;
      OPC_BYTE_LO:  mode = MODE_BYTE_LO;
      OPC_DBL_HI:   mode = MODE_DBL_HI;
      OPC_DBL_LO:   mode = MODE_DBL_LO;
      default:      mode = MODE_NONE;
    endcase
  end

  always_comb begin
    strobe.capture   = inValid;
    strobe.validNext = inValid;
  end

  if (OUT_STAGE != 0) begin : g_validReg
    always_ff @(posedge clk) begin
      if (rst) outValid <= 1'b0;
      else     outValid <= strobe.validNext;
    end
  end else begin : g_validComb
    assign outValid = strobe.validNext;
  end
endmodule

// File: rtl/pxmul_dpath.sv
module pxmul_dpath
  import pxmul_pkg::*;
#(
  parameter int OUT_STAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  mulMode_t          mode,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] contrib [LANE_CNT];
  logic [DATA_W-1:0] nextRes;
  logic              laneSel;
  logic              dblSel;

  assign laneSel = (mode == MODE_LANE) || (mode == MODE_ALPHA_HI) || (mode == MODE_ALPHA_LO) ||
                   (mode == MODE_BYTE_HI) || (mode == MODE_BYTE_LO);
  assign dblSel  = (mode == MODE_DBL_HI) || (mode == MODE_DBL_LO);

  for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
    logic [PIX_W-1:0]  pix;
    logic [COEF_W-1:0] coef;
    logic [COEF_W-1:0] mid;

    always_comb begin
      unique case (mode)
        MODE_LANE, MODE_ALPHA_HI, MODE_ALPHA_LO: pix = srcA[PIX_W*i +: PIX_W];
        MODE_BYTE_HI, MODE_DBL_HI:               pix = srcA[COEF_W*i+PIX_W +: PIX_W];
        MODE_BYTE_LO, MODE_DBL_LO:               pix = srcA[COEF_W*i +: PIX_W];
        default:                                 pix = '0;
      endcase
    end

    always_comb begin
      unique case (mode)
        MODE_ALPHA_HI: coef = srcB[2*COEF_W-1:COEF_W];
        MODE_ALPHA_LO: coef = srcB[COEF_W-1:0];
        default:       coef = srcB[COEF_W*i +: COEF_W];
      endcase
    end

    assign mid = scaleMid(pix, coef);

    if (i < DBL_CNT) begin : g_dblCap
      assign contrib[i] = laneSel ? (DATA_W'(mid) << (COEF_W*i)) :
                          dblSel  ? (DATA_W'(mid) << (2*COEF_W*i + DBL_OFS)) : '0;
    end else begin : g_laneOnly
      assign contrib[i] = laneSel ? (DATA_W'(mid) << (COEF_W*i)) : '0;
    end
  end

  always_comb begin
    nextRes = '0;
    for (int k = 0; k < LANE_CNT; k++) nextRes = nextRes | contrib[k];
  end

  if (OUT_STAGE != 0) begin : g_resReg
    always_ff @(posedge clk) begin
      if (rst)                 result <= '0;
      else if (strobe.capture) result <= nextRes;
    end
  end else begin : g_resComb
    assign result = nextRes;
  end
endmodule

// File: rtl/pixel_scale_mul.sv
module pixel_scale_mul
  import pxmul_pkg::*;
#(
  parameter int OUT_STAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  mulMode_t    mode;
  ctrlStrobe_t strobe;

  pxmul_ctrl #(.OUT_STAGE(OUT_STAGE)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .mode(mode), .strobe(strobe), .outValid(outValid)
  );

  pxmul_dpath #(.OUT_STAGE(OUT_STAGE)) u_dpath (
    .clk(clk), .rst(rst), .mode(mode), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .result(result)
  );
endmodule

// File: rtl/pxmul_checker.sv
module pxmul_checker
  import pxmul_pkg::*;
#(
  parameter int OUT_STAGE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OPC_W-1:0]  opCode,
  input logic              outValid,
  input logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] DBL_MASK =
    (64'hFFFF << DBL_OFS) | (64'hFFFF << (2*COEF_W + DBL_OFS));

  function automatic logic knownCode(input logic [OPC_W-1:0] c);
    return (c == OPC_LANE) || (c == OPC_ALPHA_HI) || (c == OPC_ALPHA_LO) ||
           (c == OPC_BYTE_HI) || (c == OPC_BYTE_LO) ||
           (c == OPC_DBL_HI) || (c == OPC_DBL_LO);
  endfunction

  if (OUT_STAGE != 0) begin : g_reg
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
      inValid |=> outValid);
    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
      !inValid |=> !outValid);
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
      !outValid |-> $stable(result));
    assert_dbl_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
      (outValid && (($past(opCode) == OPC_DBL_HI) || ($past(opCode) == OPC_DBL_LO)))
        |-> ((result & ~DBL_MASK) == '0));
    assert_unknown_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (outValid && !knownCode($past(opCode))) |-> (result == '0));
    assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!outValid && (result == '0)));
  end
endmodule

bind pixel_scale_mul pxmul_checker #(.OUT_STAGE(OUT_STAGE)) u_pxmul_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
  .outValid(outValid), .result(result)
);

// File: tb/test_pixel_scale_mul.sv
module test_pixel_scale_mul;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [8:0]  opCode = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic [63:0] expRes = '0;
  string       expTag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_scale_mul i_pixel_scale_mul (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result)
  );

  function automatic logic [15:0] refMid(int unsigned p, logic [15:0] c);
    longint pr;
    pr = longint'(p) * longint'($signed(c));
    return 16'((((pr >>> 8) & 64'hFFFF) + ((pr >>> 7) & 64'h1)) & 64'hFFFF);
  endfunction

  function automatic logic [63:0] refMul(logic [8:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    case (op)
      9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = refMid(a[8*i +: 8], b[16*i +: 16]);
      9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = refMid(a[8*i +: 8], b[31:16]);
      9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = refMid(a[8*i +: 8], b[15:0]);
      9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = refMid(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = refMid(a[16*i +: 8], b[16*i +: 16]);
      9'h038: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = refMid(a[16*i+8 +: 8], b[16*i +: 16]);
      9'h039: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = refMid(a[16*i +: 8], b[16*i +: 16]);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(logic [8:0] op);
    case (op)
      9'h031:         return "R1";
      9'h033, 9'h035: return "R3";
      9'h036, 9'h037: return "R4";
      9'h038, 9'h039: return "R5";
      default:        return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model is stepped at each rising edge; outputs compared every cycle.
  always @(posedge clk) begin
    if (rst) begin
      expValid <= 1'b0;
      expRes   <= '0;
      expTag   <= "R9";
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expRes <= refMul(opCode, srcA, srcB);
        expTag <= tagOf(opCode);
      end else begin
        expTag <= "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (!done && !rst) begin
      check("R8", {63'd0, outValid}, {63'd0, expValid});
      check(expTag, result, expRes);
    end
  end

  task automatic drive(bit v, logic [8:0] op, logic [63:0] a, logic [63:0] b);
    inValid = v; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is held
    check("R9", {63'd0, outValid}, 64'd0);
    check("R9", result, 64'd0);
    rst = 1'b0;

    // R1 basic lanes
    drive(1, 9'h031, 64'h0000_0000_4010_FF02, 64'h1234_8000_7FFF_0101);
    // R2 rounding and wrap: lanes give 0x0000, 0x0001, 0x0080, 0x7F7F
    drive(1, 9'h031, 64'h0000_0000_FF80_0101, 64'h7FFF_0100_0080_FFFF);
    check("R2", result, 64'h7F7F_0080_0001_0000);
    // R3 shared coefficient, upper then lower
    drive(1, 9'h033, 64'h0000_0000_11FF_8001, 64'h0000_0000_C350_0123);
    drive(1, 9'h035, 64'h0000_0000_11FF_8001, 64'h0000_0000_C350_0123);
    // R4 byte selection from 16-bit lanes
    drive(1, 9'h036, 64'hAB12_CD34_EF56_0178, 64'h0100_FF00_8001_7FFF);
    drive(1, 9'h037, 64'hAB12_CD34_EF56_0178, 64'h0100_FF00_8001_7FFF);
    // R5 double-width placement, other bits zero
    drive(1, 9'h038, 64'h0000_0000_FF80_7F01, 64'h0000_0000_FFFF_8000);
    check("R5", result & ~((64'hFFFF << 7) | (64'hFFFF << 39)), 64'd0);
    drive(1, 9'h039, 64'h0000_0000_FF80_7F01, 64'h0000_0000_FFFF_8000);
    // R6 upper halves ignored for 32-bit operand forms
    begin
      logic [63:0] base;
      drive(1, 9'h033, 64'h0000_0000_A1B2_C3D4, 64'h0000_0000_1357_9BDF);
      base = result;
      drive(1, 9'h033, 64'hDEAD_BEEF_A1B2_C3D4, 64'hCAFE_F00D_1357_9BDF);
      check("R6", result, base);
      drive(1, 9'h038, 64'h0000_0000_A1B2_C3D4, 64'h0000_0000_1357_9BDF);
      base = result;
      drive(1, 9'h038, 64'hFFFF_FFFF_A1B2_C3D4, 64'h5555_AAAA_1357_9BDF);
      check("R6", result, base);
      drive(1, 9'h031, 64'h0000_0000_A1B2_C3D4, 64'h0011_2233_4455_6677);
      base = result;
      drive(1, 9'h031, 64'h7777_1111_A1B2_C3D4, 64'h0011_2233_4455_6677);
      check("R6", result, base);
    end
    // R7 unknown code gives zero, valid
    drive(1, 9'h034, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    check("R7", result, 64'd0);
    check("R7", {63'd0, outValid}, 64'd1);
    // R8 idle cycles hold the last result
    drive(1, 9'h031, 64'h0000_0000_0102_0304, 64'h0100_0200_0300_0400);
    drive(0, 9'h039, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8", result, 64'h0001_0004_0009_0010);
    drive(0, 9'h031, '0, '0);
    check("R8", {63'd0, outValid}, 64'd0);

    // random traffic across all codes
    for (int n = 0; n < 400; n++) begin
      logic [8:0] ops [9] = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037,
                              9'h038, 9'h039, 9'h000, 9'h03A};
      drive(($urandom % 4) != 0, ops[$urandom % 9],
            {$urandom, $urandom}, {$urandom, $urandom});
    end
    drive(0, '0, '0, '0);

    // R9 reset mid-stream
    drive(1, 9'h031, 64'hFF, 64'h7FFF);
    rst = 1'b1;
    @(negedge clk);
    check("R9", {63'd0, outValid}, 64'd0);
    check("R9", result, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule